// File: doc/BRIEF.md
# Serial Interface Counter and Control

This block is the counting and control core of a general-purpose serial port. It holds an 8-bit shift register, a 4-bit event counter with a sticky overflow flag, and a control register. The control register picks the clock source that drives the counter and the shift register, sets how the data and clock pads are driven, and enables the two interrupt requests. Software reaches the block through a small register bus with three locations: control, data and status.

The counter can be stepped from four places: a bus strobe, a periodic tick from a neighbouring timer, both edges of an external serial clock pin, and a clock-toggle strobe. When the counter is preset to all ones, a single event overflows it. The overflow flag then serves as an edge interrupt or a software interrupt. The external clock and data pins pass through a two-stage synchronizer first. Start-condition detection happens outside the block and arrives as a pulse input.

Top module: `sif_core`

## Requirements
- R1: After reset every register reads 0. Control (address 0) reads back bits 7:2 as written. Bits 1 (clock strobe) and 0 (toggle strobe) always read 0.
- R2: Clock select (control bits 3:2) = 00: writing control bit 1 steps the counter by one and shifts one synchronized data bit into the shift register. The same strobe has no effect under any other clock select.
- R3: Clock select = 01: each cycle with tick_i high steps the counter and shifts one bit. Ticks have no effect under any other clock select.
- R4: Clock select = 10 or 11: the counter steps on both the rising and the falling edge of ext_clk_i. A pin change made before clock edge 0 is counted at clock edge 2. Under select 00 or 01, pin edges do not move the counter.
- R5: The shift register shifts only on rising pin edges under select 10 and only on falling pin edges under select 11. The new bit enters at bit 0 and the old bits move toward bit 7.
- R6: A wrap from 15 to 0 sets the overflow flag (status bit 6). irq_ovf_o is high while the flag and control bit 6 are both set. Enabling with the flag already pending raises the request in the cycle after the write.
- R7: Writing status with bit 6 = 1 clears the overflow flag. Writing 0 there leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R8: Writing control bit 0 inverts the clock output register (status bit 5) under any select. Under select 10 or 11 it also adds one count. When it coincides with a counted pin edge, the counter advances by two.
- R9: Wire mode (control bits 5:4) sets the outputs. 00: both output enables are low. 01: data_oe_o and clk_oe_o are high, data_o is shift bit 7 and clk_o is the clock register. 10: data_o = clk_o = 0, data_oe_o = NOT bit 7, clk_oe_o = NOT clock register. 11: same as 10, but clk_oe_o is also high while the overflow flag is set.
- R10: A start_det_i pulse sets the start flag (status bit 7). irq_start_o is that flag ANDed with control bit 7. Writing 1 to status bit 7 clears the flag.
- R11: A status write with bit 4 = 1 loads bits 3:0 into the counter. The load wins over a count in the same cycle and raises no overflow. After a preset to 15, a single event overflows the counter.
- R12: A write to the data register (address 1) loads the shift register. The load wins over a shift in the same cycle. The data register reads back the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 2 | Register address: 0 control, 1 data, 2 status |
| bus_we_i | input | 1 | Write enable, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| ext_clk_i | input | 1 | External serial clock pin |
| data_i | input | 1 | Serial data pin |
| tick_i | input | 1 | Periodic timer tick, one cycle wide |
| start_det_i | input | 1 | Start-condition detected pulse |
| data_o | output | 1 | Data pad output value |
| data_oe_o | output | 1 | Data pad output enable |
| clk_o | output | 1 | Clock pad output value |
| clk_oe_o | output | 1 | Clock pad output enable |
| irq_ovf_o | output | 1 | Counter overflow interrupt request |
| irq_start_o | output | 1 | Start-condition interrupt request |

## Verification
Several functions can fall in the same clock cycle, and the bench aims at exactly those cycles. A toggle strobe is written in the cycle in which a synchronized pin edge is counted, and the bench expects a step of two. A tick that wraps the counter is issued in the same cycle as a write that clears the overflow flag, and the flag must stay set. A tick also meets a counter preset and a data-register write, and the bus load must win in both. Each collision is set up by counting the two synchronizer stages from the pin change to the cycle in which the edge is counted. The registers are read back immediately afterwards.

// File: rtl/sif_pkg.sv
package sif_pkg;
  typedef enum logic [1:0] {
    CS_SOFT     = 2'b00,
    CS_TICK     = 2'b01,
    CS_EXT_RISE = 2'b10,
    CS_EXT_FALL = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    WM_OFF       = 2'b00,
    WM_PUSH      = 2'b01,
    WM_OPEN      = 2'b10,
    WM_OPEN_HOLD = 2'b11
  } wire_mode_e;

  typedef struct packed {
    logic       start_ie;
    logic       ovf_ie;
    wire_mode_e wm;
    clk_sel_e   cs;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int unsigned CTRL_STROBE_BIT = 1;
  localparam int unsigned CTRL_TOGGLE_BIT = 0;
  localparam int unsigned STAT_START_BIT  = 7;
  localparam int unsigned STAT_OVF_BIT    = 6;
  localparam int unsigned STAT_CLKQ_BIT   = 5;
  localparam int unsigned STAT_LOAD_BIT   = 4;
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sif_clk_counter.sv
module sif_clk_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CNT_W:0]   sum;
  logic             wrap;

  assign sum  = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc_i};
  assign wrap = sum[CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= load_i ? load_val_i : sum[CNT_W-1:0];
      // set beats clear
      if (!load_i && wrap) ovf_q <= 1'b1;
      else if (ovf_clr_i)  ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  assert_wrap_sets_ovf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && inc_i != 2'd0 && !load_i) |=> ovf_q);
  assert_clear_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && (inc_i == 2'd0 || load_i)) |=> !ovf_q);
  assert_load_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/sif_shift_reg.sv
module sif_shift_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] sr_o
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= load_val_i;
    else if (shift_i) sr_q <= {sr_q[DATA_W-2:0], bit_i};
  end

  assign sr_o = sr_q;

  assert_shift_moves_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> sr_q[DATA_W-1:1] == $past(sr_q[DATA_W-2:0]));
  assert_hold_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(sr_q));
endmodule

// File: rtl/sif_core.sv
module sif_core
  import sif_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ext_clk_i,
  input  logic              data_i,
  input  logic              tick_i,
  input  logic              start_det_i,
  output logic              data_o,
  output logic              data_oe_o,
  output logic              clk_o,
  output logic              clk_oe_o,
  output logic              irq_ovf_o,
  output logic              irq_start_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic              clk_q, start_q, ext_last_q;
  logic [1:0]        pins_sync;
  logic              ext_s, data_s, ext_rise, ext_fall, ext_edge, ext_sel;
  logic              wr_ctrl, wr_data, wr_stat;
  logic              strobe_clk, strobe_tog;
  logic              soft_evt, tick_evt, shift_evt;
  logic [1:0]        cnt_inc;
  logic [CNT_W-1:0]  cnt;
  logic              ovf;
  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] stat_word, ctrl_word;

  sif_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({data_i, ext_clk_i}),
    .q_o   (pins_sync)
  );
  assign ext_s  = pins_sync[0];
  assign data_s = pins_sync[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_last_q <= 1'b0;
    else         ext_last_q <= ext_s;
  end
  assign ext_rise = ext_s & ~ext_last_q;
  assign ext_fall = ~ext_s & ext_last_q;
  assign ext_edge = ext_rise | ext_fall;

  assign wr_ctrl    = bus_we_i && bus_addr_i == ADDR_CTRL;
  assign wr_data    = bus_we_i && bus_addr_i == ADDR_DATA;
  assign wr_stat    = bus_we_i && bus_addr_i == ADDR_STAT;
  assign strobe_clk = wr_ctrl & bus_wdata_i[CTRL_STROBE_BIT];
  assign strobe_tog = wr_ctrl & bus_wdata_i[CTRL_TOGGLE_BIT];

  // strobes act on the clock select held before the write
  assign ext_sel  = ctrl_q.cs[1];
  assign soft_evt = (ctrl_q.cs == CS_SOFT) & strobe_clk;
  assign tick_evt = (ctrl_q.cs == CS_TICK) & tick_i;
  assign cnt_inc  = {1'b0, soft_evt | tick_evt | (ext_sel & ext_edge)}
                  + {1'b0, ext_sel & strobe_tog};

  always_comb begin
    unique case (ctrl_q.cs)
      CS_SOFT:     shift_evt = soft_evt;
      CS_TICK:     shift_evt = tick_evt;
      CS_EXT_RISE: shift_evt = ext_rise;
      default:     shift_evt = ext_fall;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      clk_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i[DATA_W-1 -: CTRL_W]);
      if (strobe_tog) clk_q <= ~clk_q;
      if (start_det_i) start_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[STAT_START_BIT]) start_q <= 1'b0;
    end
  end

  sif_clk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (cnt_inc),
    .load_i    (wr_stat & bus_wdata_i[STAT_LOAD_BIT]),
    .load_val_i(bus_wdata_i[CNT_W-1:0]),
    .ovf_clr_i (wr_stat & bus_wdata_i[STAT_OVF_BIT]),
    .cnt_o     (cnt),
    .ovf_o     (ovf)
  );

  sif_shift_reg #(.DATA_W(DATA_W)) u_sr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift_evt),
    .bit_i     (data_s),
    .load_i    (wr_data),
    .load_val_i(bus_wdata_i),
    .sr_o      (sr)
  );

  always_comb begin
    data_o    = 1'b0;
    data_oe_o = 1'b0;
    clk_o     = 1'b0;
    clk_oe_o  = 1'b0;
    unique case (ctrl_q.wm)
      WM_OFF: ;
      WM_PUSH: begin
        data_o    = sr[DATA_W-1];
        data_oe_o = 1'b1;
        clk_o     = clk_q;
        clk_oe_o  = 1'b1;
      end
      WM_OPEN: begin
        data_oe_o = ~sr[DATA_W-1];
        clk_oe_o  = ~clk_q;
      end
      default: begin
        data_oe_o = ~sr[DATA_W-1];
        clk_oe_o  = ~clk_q | ovf;
      end
    endcase
  end

  always_comb begin
    stat_word                 = '0;
    stat_word[STAT_START_BIT] = start_q;
    stat_word[STAT_OVF_BIT]   = ovf;
    stat_word[STAT_CLKQ_BIT]  = clk_q;
    stat_word[CNT_W-1:0]      = cnt;
    ctrl_word                 = '0;
    ctrl_word[DATA_W-1 -: CTRL_W] = ctrl_q;
    unique case (bus_addr_i)
      ADDR_CTRL: bus_rdata_o = ctrl_word;
      ADDR_DATA: bus_rdata_o = sr;
      ADDR_STAT: bus_rdata_o = stat_word;
      default:   bus_rdata_o = '0;
    endcase
  end

  assign irq_ovf_o   = ovf & ctrl_q.ovf_ie;
  assign irq_start_o = start_q & ctrl_q.start_ie;

  assert_one_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_rise && ext_fall));
  assert_strobe_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && ctrl_q.cs == CS_TICK && !tick_i) |=> $stable(cnt));
  assert_released_pads_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.wm == WM_OFF) |-> (!data_oe_o && !clk_oe_o));
  assert_pending_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && wr_ctrl && bus_wdata_i[DATA_W-2] && !(wr_stat)) |=> irq_ovf_o);
endmodule

// File: tb/sif_core_tb_top.sv
`timescale 1ns/1ps
module sif_core_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic       bus_we_i = 1'b0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       ext_clk_i = 1'b0, data_i = 1'b0, tick_i = 1'b0, start_det_i = 1'b0;
  logic       data_o, data_oe_o, clk_o, clk_oe_o, irq_ovf_o, irq_start_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  sif_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .ext_clk_i(ext_clk_i),
    .data_i(data_i), .tick_i(tick_i), .start_det_i(start_det_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .clk_o(clk_o), .clk_oe_o(clk_oe_o),
    .irq_ovf_o(irq_ovf_o), .irq_start_o(irq_start_o)
  );

  // {ctrl write, data write, expected {data_o,data_oe_o,clk_o,clk_oe_o}}
  localparam logic [19:0] PAD_VEC [8] = '{
    {8'h00, 8'h80, 4'b0000}, {8'h00, 8'h00, 4'b0000},
    {8'h10, 8'h80, 4'b1101}, {8'h10, 8'h00, 4'b0101},
    {8'h20, 8'h80, 4'b0001}, {8'h20, 8'h00, 4'b0101},
    {8'h30, 8'h80, 4'b0001}, {8'h30, 8'h00, 4'b0101}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  task automatic tick_pulse();
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic pin(input logic v);
    ext_clk_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    bus_we_i = 1'b0; tick_i = 1'b0; start_det_i = 1'b0; ext_clk_i = 1'b0; data_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state
    rd(ADDR_C, v); chk("R1 ctrl reset", v, 8'h00);
    rd(ADDR_S, v); chk("R1 status reset", v, 8'h00);
    rd(ADDR_D, v); chk("R1 data reset", v, 8'h00);
    chk("R1 irq reset", {irq_ovf_o, irq_start_o}, 2'b00);
    chk("R9 pads released at reset", {data_oe_o, clk_oe_o}, 2'b00);

    // R9 wire mode table
    for (int i = 0; i < 8; i++) begin
      wr(ADDR_C, PAD_VEC[i][19:12]);
      wr(ADDR_D, PAD_VEC[i][11:4]);
      #1;
      chk($sformatf("R9 pad vector %0d", i), {data_o, data_oe_o, clk_o, clk_oe_o}, PAD_VEC[i][3:0]);
    end

    // R1 readback, strobes read 0
    wr(ADDR_C, 8'hFC); rd(ADDR_C, v); chk("R1 ctrl readback", v, 8'hFC);
    do_reset();
    wr(ADDR_C, 8'hC3); rd(ADDR_C, v); chk("R1 strobe bits read 0", v, 8'hC0);

    // R2 software strobe
    do_reset();
    data_i = 1'b1; repeat (3) @(negedge clk_i);
    wr(ADDR_C, 8'h02);
    rd(ADDR_S, v); chk("R2 strobe counts", v[3:0], 4'd1);
    rd(ADDR_D, v); chk("R2 strobe shifts", v, 8'h01);
    wr(ADDR_C, 8'h04);
    wr(ADDR_C, 8'h06);
    rd(ADDR_S, v); chk("R2 strobe ignored in tick mode", v[3:0], 4'd1);

    // R3 tick
    tick_pulse();
    rd(ADDR_S, v); chk("R3 tick counts", v[3:0], 4'd2);
    rd(ADDR_D, v); chk("R3 tick shifts", v, 8'h03);
    wr(ADDR_C, 8'h00);
    tick_pulse();
    rd(ADDR_S, v); chk("R3 tick ignored in soft mode", v[3:0], 4'd2);
    rd(ADDR_D, v); chk("R3 tick no shift in soft mode", v, 8'h03);

    // R4/R5 external clock
    do_reset();
    data_i = 1'b1;
    wr(ADDR_C, 8'h08);
    ext_clk_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rd(ADDR_S, v); chk("R4 not counted before edge 2", v[3:0], 4'd0);
    @(negedge clk_i);
    rd(ADDR_S, v); chk("R4 rising edge counted at edge 2", v[3:0], 4'd1);
    rd(ADDR_D, v); chk("R5 rise shifts in rise mode", v, 8'h01);
    pin(1'b0);
    rd(ADDR_S, v); chk("R4 falling edge counted", v[3:0], 4'd2);
    rd(ADDR_D, v); chk("R5 fall no shift in rise mode", v, 8'h01);
    data_i = 1'b0;
    pin(1'b1);
    rd(ADDR_D, v); chk("R5 shift toward msb", v, 8'h02);
    wr(ADDR_C, 8'h0C);
    pin(1'b0);
    rd(ADDR_D, v); chk("R5 fall shifts in fall mode", v, 8'h04);
    pin(1'b1);
    rd(ADDR_D, v); chk("R5 rise no shift in fall mode", v, 8'h04);
    rd(ADDR_S, v); chk("R4 count in fall mode", v[3:0], 4'd5);
    wr(ADDR_C, 8'h00);
    pin(1'b0); pin(1'b1);
    rd(ADDR_S, v); chk("R4 pin ignored in soft mode", v[3:0], 4'd5);

    // R6/R11 preset and overflow
    do_reset();
    wr(ADDR_S, 8'h1F);
    rd(ADDR_S, v); chk("R11 preset 15", v, 8'h0F);
    wr(ADDR_C, 8'h08);
    pin(1'b1);
    rd(ADDR_S, v); chk("R6 single edge overflows", v, 8'h40);
    chk("R6 irq masked", irq_ovf_o, 1'b0);
    wr(ADDR_C, 8'h48); #1;
    chk("R6 pending irq on enable", irq_ovf_o, 1'b1);
    wr(ADDR_S, 8'h00);
    rd(ADDR_S, v); chk("R7 write 0 keeps flag", v[6], 1'b1);
    wr(ADDR_S, 8'h40);
    rd(ADDR_S, v); chk("R7 write 1 clears flag", v[6], 1'b0);
    chk("R7 irq drops", irq_ovf_o, 1'b0);
    wr(ADDR_C, 8'h44);
    wr(ADDR_S, 8'h1F);
    tick_pulse();
    wr(ADDR_S, 8'h1F);
    tick_i = 1'b1; wr(ADDR_S, 8'h40); tick_i = 1'b0;
    rd(ADDR_S, v); chk("R7 set wins over clear", v, 8'h40);
    tick_i = 1'b1; wr(ADDR_S, 8'h15); tick_i = 1'b0;
    rd(ADDR_S, v); chk("R11 load wins over tick", v, 8'h45);

    // R12 data load beats shift
    data_i = 1'b1; repeat (3) @(negedge clk_i);
    tick_i = 1'b1; wr(ADDR_D, 8'hA5); tick_i = 1'b0;
    rd(ADDR_D, v); chk("R12 load wins over shift", v, 8'hA5);
    rd(ADDR_S, v); chk("R12 tick still counted", v[3:0], 4'd6);

    // R8 toggle strobe
    do_reset();
    wr(ADDR_C, 8'h11); #1;
    chk("R8 toggle inverts clock", clk_o, 1'b1);
    rd(ADDR_S, v); chk("R8 no count in soft mode", v, 8'h20);
    wr(ADDR_C, 8'h18);
    wr(ADDR_C, 8'h19);
    rd(ADDR_S, v); chk("R8 toggle counts in ext mode", v, 8'h01);
    ext_clk_i = 1'b1;
    repeat (2) @(negedge clk_i);
    wr(ADDR_C, 8'h19);
    rd(ADDR_S, v); chk("R8 edge plus toggle adds two", v, 8'h23);

    // R9 clock hold on overflow
    do_reset();
    wr(ADDR_C, 8'h30);
    wr(ADDR_D, 8'h80);
    wr(ADDR_C, 8'h31); #1;
    chk("R9 open mode clock released", clk_oe_o, 1'b0);
    wr(ADDR_S, 8'h1F);
    wr(ADDR_C, 8'h32); #1;
    chk("R9 hold mode drives clock on overflow", clk_oe_o, 1'b1);

    // R10 start flag
    do_reset();
    start_det_i = 1'b1; @(negedge clk_i); start_det_i = 1'b0;
    rd(ADDR_S, v); chk("R10 start flag set", v[7], 1'b1);
    chk("R10 irq masked", irq_start_o, 1'b0);
    wr(ADDR_C, 8'h80); #1;
    chk("R10 irq on enable", irq_start_o, 1'b1);
    wr(ADDR_S, 8'h80);
    rd(ADDR_S, v); chk("R10 flag cleared", v[7], 1'b0);
    chk("R10 irq cleared", irq_start_o, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  localparam logic [1:0] ADDR_C = 2'd0;
  localparam logic [1:0] ADDR_D = 2'd1;
  localparam logic [1:0] ADDR_S = 2'd2;
endmodule